// File: doc/BRIEF.md
# Host Board-Control Register and Interrupt Block

This block sits between a PC-style I/O bus and the control logic of an accelerator board. A two-bit switch places the board at one of three I/O bases or removes it from the bus. Inside the chosen window, the four lowest locations belong to an external serial-link adapter. This block only decodes a select and a registered write strobe for that adapter. The block's own system registers sit sixteen locations above the base.

The system registers hold two latched control levels, reset and analyse, and report the board error flag on reads. A write-only enable nibble picks which of four events may raise a single host interrupt:

- DMA end of transfer,
- error,
- output ready,
- input ready.

A level-select input steers that interrupt to one of two interrupt pins. The pin stays undriven until software enables at least one event, so that it does not disturb a shared line. The DMA event is captured on the falling edge of end-of-transfer into a sticky latch, which clears only when its enable bit is cleared. The other three events act as levels.

Top module: `hostctl_regs`

## Requirements
- R1: base_sel 1, 2 and 3 place the window at 0x150, 0x200 and 0x300. base_sel 0 decodes nothing. adp_sel is high exactly for window offsets 0..3.
- R2: While aen is high, adp_sel stays low, data_oe stays low and writes are ignored.
- R3: A write to base+0x10 loads data_in[0] into rst_out, where 1 means asserted. The value is visible two clock edges after iow_n is sampled low and is held until rewritten.
- R4: A write to base+0x11 loads data_in[0] into anl_out in the same way.
- R5: A read (ior_n low) of base+0x10..0x12 drives data_oe high, with data_out = {3'b000, evt_error}. A read of base+0x13 leaves data_oe low.
- R6: A write to base+0x13 loads the enable nibble: bit 0 is DMA end, bit 1 is error, bit 2 is output ready and bit 3 is input ready. All bits are 0 after reset.
- R7: While the enable nibble is zero, irq3_oe and irq5_oe are both low.
- R8: With any enable bit set, the selected pin's enable is high. Its value is 0 while no enabled event is active and 1 while one is.
- R9: irq_level_sel 0 enables irq3 and 1 enables irq5. The two enables are never high together.
- R10: Enable bit 0 gates the DMA-end latch:
  - The latch sets on the registered falling edge of dma_eot, and only while bit 0 is 1. It then holds, even if dma_eot rises again.
  - Clearing bit 0 clears the latch.
  - Setting bit 0 again does not raise the interrupt until the next falling edge.
- R11: The error, output-ready and input-ready events drive the interrupt combinationally while they and their enable bits are set.
- R12: adp_wr is the registered copy of the I/O write strobe, qualified by an adapter-window hit. It goes high one clock edge after iow_n is sampled low and never goes high for system-register writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 10 | I/O address |
| iow_n | input | 1 | I/O write strobe, active low |
| ior_n | input | 1 | I/O read strobe, active low |
| aen | input | 1 | DMA address enable; high blocks decode |
| data_in | input | 4 | Write data nibble |
| base_sel | input | 2 | Base-address switch |
| evt_error | input | 1 | Board error flag |
| evt_out_rdy | input | 1 | Adapter ready to accept data |
| evt_in_rdy | input | 1 | Adapter holding data for host |
| dma_eot | input | 1 | DMA end-of-transfer level |
| irq_level_sel | input | 1 | 0 steers to irq3, 1 to irq5 |
| data_out | output | 4 | Read data |
| data_oe | output | 1 | Read data drive enable |
| adp_sel | output | 1 | Adapter chip select |
| adp_wr | output | 1 | Registered adapter write strobe |
| rst_out | output | 1 | Latched reset level |
| anl_out | output | 1 | Latched analyse level |
| irq3 | output | 1 | Interrupt value for pin 3 |
| irq3_oe | output | 1 | Drive enable for pin 3 |
| irq5 | output | 1 | Interrupt value for pin 5 |
| irq5_oe | output | 1 | Drive enable for pin 5 |

## Verification
The results fall into four timing groups:

- Decode outputs, read data and the level interrupts are combinational. The bench checks them in the same half cycle in which it drives their inputs.
- adp_wr appears after one clock edge.
- Control registers and enables update on the second edge after the write strobe is first sampled. The write task therefore spans three falling edges before anything is read.
- The DMA latch needs two edges after dma_eot falls: one to register the level and one to set the latch. Its interrupt is sampled two falling edges after the drop, and is checked again after dma_eot rises to show that the latch holds.

// File: rtl/hostctl_pkg.sv
// hostctl_pkg: shared constants and the base-address lookup for the
// host register block. Assumes a 10-bit I/O address space.
package hostctl_pkg;
    localparam int ADDR_W  = 10;
    localparam int DATA_W  = 4;
    localparam int N_EVT   = 4;
    localparam int SYS_OFS = 'h10;

    // system register offsets within the system window
    localparam logic [1:0] OFS_RST = 2'd0;
    localparam logic [1:0] OFS_ANL = 2'd1;
    localparam logic [1:0] OFS_IEN = 2'd3;

    // enable bit positions
    localparam int EV_DMA = 0;
    localparam int EV_ERR = 1;
    localparam int EV_OUT = 2;
    localparam int EV_IN  = 3;

    // base address for each switch setting; 0 means board absent
    function automatic logic [ADDR_W-1:0] base_of(input logic [1:0] sel);
        case (sel)
            2'd1:    base_of = ADDR_W'('h150);
            2'd2:    base_of = ADDR_W'('h200);
            2'd3:    base_of = ADDR_W'('h300);
            default: base_of = '0;
        endcase
    endfunction
endpackage

// File: rtl/hostctl_decode.sv
// hostctl_decode: combinational window decode. Produces the adapter-window
// and system-window hits and the register offset. Assumes aen high
// marks DMA cycles that must not decode.
module hostctl_decode
    import hostctl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              aen,
    input  logic [1:0]        base_sel,
    output logic              adp_hit,
    output logic              sys_hit,
    output logic [1:0]        ofs
);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] sys_base;
    logic              live;

    // window match on the address above the two offset bits
    always_comb begin
        base     = base_of(base_sel);
        sys_base = base + ADDR_W'(SYS_OFS);
        live     = (base_sel != 2'd0) && !aen;
        adp_hit  = live && (addr[ADDR_W-1:2] == base[ADDR_W-1:2]);
        sys_hit  = live && (addr[ADDR_W-1:2] == sys_base[ADDR_W-1:2]);
        ofs      = addr[1:0];
    end
endmodule

// File: rtl/hostctl_ctrl.sv
// hostctl_ctrl: registers the write strobe with its decoded target, then
// commits system-register writes one edge later. Also produces the
// registered adapter write strobe. Assumes strobes are synchronous to clk.
module hostctl_ctrl
    import hostctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iow_n,
    input  logic              adp_hit,
    input  logic              sys_hit,
    input  logic [1:0]        ofs,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_q,
    output logic              adp_wr,
    output logic              rst_lvl,
    output logic              anl_lvl,
    output logic [N_EVT-1:0]  ien
);
    logic              adp_q;
    logic              sys_q;
    logic [1:0]        ofs_q;
    logic [DATA_W-1:0] dat_q;

    // stage 1: capture strobe, target and data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= 1'b0;
            adp_q <= 1'b0;
            sys_q <= 1'b0;
            ofs_q <= '0;
            dat_q <= '0;
        end else begin
            wr_q  <= !iow_n;
            adp_q <= adp_hit;
            sys_q <= sys_hit;
            ofs_q <= ofs;
            dat_q <= wdata;
        end
    end

    // stage 2: commit the captured write to the addressed register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_lvl <= 1'b0;
            anl_lvl <= 1'b0;
            ien     <= '0;
        end else if (wr_q && sys_q) begin
            case (ofs_q)
                OFS_RST: rst_lvl <= dat_q[0];
                OFS_ANL: anl_lvl <= dat_q[0];
                OFS_IEN: ien     <= dat_q[N_EVT-1:0];
                default: ;
            endcase
        end
    end

    // adapter write strobe follows the registered strobe
    assign adp_wr = wr_q && adp_q;
endmodule

// File: rtl/hostctl_irq.sv
// hostctl_irq: combines the enabled events into one interrupt. Holds the
// sticky DMA-end latch and steers the line to one of two pins. Assumes
// dma_eot is synchronous to clk.
module hostctl_irq
    import hostctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] ien,
    input  logic             dma_eot,
    input  logic             evt_error,
    input  logic             evt_out_rdy,
    input  logic             evt_in_rdy,
    input  logic             level_sel,
    output logic             dma_lat,
    output logic             irq3,
    output logic             irq3_oe,
    output logic             irq5,
    output logic             irq5_oe
);
    logic eot_q;
    logic eot_qq;
    logic eot_fall;
    logic any_en;
    logic line;

    // register end-of-transfer twice to find its falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eot_q  <= 1'b0;
            eot_qq <= 1'b0;
        end else begin
            eot_q  <= dma_eot;
            eot_qq <= eot_q;
        end
    end

    assign eot_fall = eot_qq && !eot_q;

    // sticky latch: set on a fall while enabled, clear when disabled
    always_ff @(posedge clk) begin
        if (!rst_n)           dma_lat <= 1'b0;
        else if (!ien[EV_DMA]) dma_lat <= 1'b0;
        else if (eot_fall)     dma_lat <= 1'b1;
    end

    // merge the latched and level events and steer to one pin
    always_comb begin
        any_en  = |ien;
        line    = dma_lat
                | (ien[EV_ERR] && evt_error)
                | (ien[EV_OUT] && evt_out_rdy)
                | (ien[EV_IN]  && evt_in_rdy);
        irq3_oe = any_en && !level_sel;
        irq5_oe = any_en &&  level_sel;
        irq3    = line;
        irq5    = line;
    end
endmodule

// File: rtl/hostctl_regs.sv
// hostctl_regs: top of the host board-control register block. It decodes
// the bus window, holds the control registers and drives the interrupt
// pins. The link adapter itself lives outside; this block only selects it.
module hostctl_regs
    import hostctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              iow_n,
    input  logic              ior_n,
    input  logic              aen,
    input  logic [DATA_W-1:0] data_in,
    input  logic [1:0]        base_sel,
    input  logic              evt_error,
    input  logic              evt_out_rdy,
    input  logic              evt_in_rdy,
    input  logic              dma_eot,
    input  logic              irq_level_sel,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              adp_sel,
    output logic              adp_wr,
    output logic              rst_out,
    output logic              anl_out,
    output logic              irq3,
    output logic              irq3_oe,
    output logic              irq5,
    output logic              irq5_oe
);
    logic             adp_hit;
    logic             sys_hit;
    logic [1:0]       ofs;
    logic             wr_q;
    logic [N_EVT-1:0] ien;
    logic             dma_lat;

    hostctl_decode u_dec (
        .addr     (bus_addr),
        .aen      (aen),
        .base_sel (base_sel),
        .adp_hit  (adp_hit),
        .sys_hit  (sys_hit),
        .ofs      (ofs)
    );

    hostctl_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .iow_n   (iow_n),
        .adp_hit (adp_hit),
        .sys_hit (sys_hit),
        .ofs     (ofs),
        .wdata   (data_in),
        .wr_q    (wr_q),
        .adp_wr  (adp_wr),
        .rst_lvl (rst_out),
        .anl_lvl (anl_out),
        .ien     (ien)
    );

    hostctl_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ien         (ien),
        .dma_eot     (dma_eot),
        .evt_error   (evt_error),
        .evt_out_rdy (evt_out_rdy),
        .evt_in_rdy  (evt_in_rdy),
        .level_sel   (irq_level_sel),
        .dma_lat     (dma_lat),
        .irq3        (irq3),
        .irq3_oe     (irq3_oe),
        .irq5        (irq5),
        .irq5_oe     (irq5_oe)
    );

    // read path: error flag on bit 0, enable register location not driven
    always_comb begin
        adp_sel  = adp_hit;
        data_oe  = !ior_n && sys_hit && (ofs != OFS_IEN);
        data_out = {{(DATA_W-1){1'b0}}, evt_error};
    end
endmodule

// File: rtl/hostctl_sva.sv
// hostctl_sva: property checker for hostctl_regs, attached with bind.
module hostctl_sva
    import hostctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             aen,
    input logic             adp_sel,
    input logic             data_oe,
    input logic             wr_q,
    input logic             rst_out,
    input logic             anl_out,
    input logic [N_EVT-1:0] ien,
    input logic             dma_lat,
    input logic             irq3_oe,
    input logic             irq5_oe
);
    p_aen_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        aen |-> (!adp_sel && !data_oe));

    p_rst_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_q |=> $stable(rst_out));

    p_anl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_q |=> $stable(anl_out));

    p_ien_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_q |=> $stable(ien));

    p_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> (!irq3_oe && !irq5_oe));

    p_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ien != '0) |-> (irq3_oe || irq5_oe));

    p_one_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq3_oe && irq5_oe));

    p_dma_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ien[EV_DMA] |=> !dma_lat);

    p_no_reassert_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ien[EV_DMA]) |-> !dma_lat);
endmodule

bind hostctl_regs hostctl_sva u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .aen     (aen),
    .adp_sel (adp_sel),
    .data_oe (data_oe),
    .wr_q    (wr_q),
    .rst_out (rst_out),
    .anl_out (anl_out),
    .ien     (ien),
    .dma_lat (dma_lat),
    .irq3_oe (irq3_oe),
    .irq5_oe (irq5_oe)
);

// File: tb/hostctl_regs_test.sv
// hostctl_regs_test: self-checking bench. A decode vector table is walked
// first, then directed register, interrupt and strobe tests follow.
module hostctl_regs_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] bus_addr = '0;
    logic       iow_n = 1'b1;
    logic       ior_n = 1'b1;
    logic       aen = 1'b0;
    logic [3:0] data_in = '0;
    logic [1:0] base_sel = 2'd1;
    logic       evt_error = 1'b0;
    logic       evt_out_rdy = 1'b0;
    logic       evt_in_rdy = 1'b0;
    logic       dma_eot = 1'b0;
    logic       irq_level_sel = 1'b0;
    logic [3:0] data_out;
    logic       data_oe, adp_sel, adp_wr, rst_out, anl_out;
    logic       irq3, irq3_oe, irq5, irq5_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    hostctl_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .iow_n(iow_n),
        .ior_n(ior_n), .aen(aen), .data_in(data_in), .base_sel(base_sel),
        .evt_error(evt_error), .evt_out_rdy(evt_out_rdy),
        .evt_in_rdy(evt_in_rdy), .dma_eot(dma_eot),
        .irq_level_sel(irq_level_sel), .data_out(data_out),
        .data_oe(data_oe), .adp_sel(adp_sel), .adp_wr(adp_wr),
        .rst_out(rst_out), .anl_out(anl_out), .irq3(irq3),
        .irq3_oe(irq3_oe), .irq5(irq5), .irq5_oe(irq5_oe)
    );

    // vector: sel[15:14] addr[13:4] aen[3] exp_adp[2] exp_oe[1] spare[0]
    localparam logic [15:0] VEC [13] = '{
        {2'd1, 10'h150, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd1, 10'h153, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd1, 10'h154, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'd1, 10'h160, 1'b0, 1'b0, 1'b1, 1'b0},
        {2'd1, 10'h163, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'd1, 10'h150, 1'b1, 1'b0, 1'b0, 1'b0},
        {2'd2, 10'h200, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd2, 10'h212, 1'b0, 1'b0, 1'b1, 1'b0},
        {2'd2, 10'h150, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'd3, 10'h303, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd3, 10'h311, 1'b0, 1'b0, 1'b1, 1'b0},
        {2'd0, 10'h150, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'd3, 10'h310, 1'b1, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // write over three falling edges: capture edge, commit edge, release
    task automatic wr(input logic [9:0] a, input logic [3:0] d);
        bus_addr = a; data_in = d; iow_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        iow_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check("R3 reset", {7'd0, rst_out}, 8'd0);
        check("R4 reset", {7'd0, anl_out}, 8'd0);
        check("R7 reset", {6'd0, irq3_oe, irq5_oe}, 8'd0);

        // decode table (R1, R2, R5)
        evt_error = 1'b1;
        ior_n = 1'b0;
        foreach (VEC[i]) begin
            base_sel = VEC[i][15:14];
            bus_addr = VEC[i][13:4];
            aen      = VEC[i][3];
            #1;
            check("R1 adp_sel", {7'd0, adp_sel}, {7'd0, VEC[i][2]});
            check("R5 data_oe", {7'd0, data_oe}, {7'd0, VEC[i][1]});
            if (VEC[i][1])
                check("R5 data", {4'd0, data_out}, 8'd1);
            @(negedge clk);
        end
        ior_n = 1'b1; aen = 1'b0; base_sel = 2'd1; evt_error = 1'b0;
        @(negedge clk);

        // R3 and R4 latched levels
        wr(10'h160, 4'h1);
        check("R3 set", {7'd0, rst_out}, 8'd1);
        repeat (4) @(negedge clk);
        check("R3 hold", {7'd0, rst_out}, 8'd1);
        wr(10'h160, 4'h0);
        check("R3 clear", {7'd0, rst_out}, 8'd0);
        wr(10'h161, 4'h1);
        check("R4 set", {7'd0, anl_out}, 8'd1);
        check("R4 reset untouched", {7'd0, rst_out}, 8'd0);
        wr(10'h161, 4'h0);
        check("R4 clear", {7'd0, anl_out}, 8'd0);

        // R2 write with aen high is ignored
        aen = 1'b1;
        wr(10'h160, 4'h1);
        aen = 1'b0;
        check("R2 write ignored", {7'd0, rst_out}, 8'd0);

        // R6/R8/R11 error enable
        wr(10'h163, 4'b0010);
        check("R8 driven low", {6'd0, irq3_oe, irq3}, 8'b10);
        evt_error = 1'b1; #1;
        check("R11 error high", {6'd0, irq3_oe, irq3}, 8'b11);
        evt_out_rdy = 1'b1; evt_in_rdy = 1'b1; evt_error = 1'b0; #1;
        check("R6 unenabled events", {7'd0, irq3}, 8'd0);
        @(negedge clk);
        wr(10'h163, 4'b1000);
        check("R11 input ready", {7'd0, irq3}, 8'd1);
        evt_in_rdy = 1'b0; #1;
        check("R11 input cleared", {7'd0, irq3}, 8'd0);
        wr(10'h163, 4'b0100);
        check("R6 output ready bit", {7'd0, irq3}, 8'd1);
        evt_out_rdy = 1'b0;

        // R9 pin steering
        irq_level_sel = 1'b1; #1;
        check("R9 irq5", {6'd0, irq3_oe, irq5_oe}, 8'b01);
        irq_level_sel = 1'b0; #1;
        check("R9 irq3", {6'd0, irq3_oe, irq5_oe}, 8'b10);
        @(negedge clk);

        // R7 clear all enables
        wr(10'h163, 4'b0000);
        check("R7 float", {6'd0, irq3_oe, irq5_oe}, 8'd0);

        // R10 sticky DMA latch
        wr(10'h163, 4'b0001);
        dma_eot = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 no fall yet", {7'd0, irq3}, 8'd0);
        dma_eot = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10 latch set", {7'd0, irq3}, 8'd1);
        dma_eot = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 sticky", {7'd0, irq3}, 8'd1);
        wr(10'h163, 4'b0000);
        check("R10 cleared", {6'd0, irq3_oe, irq3}, 8'd0);
        wr(10'h163, 4'b0001);
        check("R10 no reassert", {6'd0, irq3_oe, irq3}, 8'b10);
        // fall while disabled must not latch
        wr(10'h163, 4'b0010);
        dma_eot = 1'b0;
        repeat (3) @(negedge clk);
        wr(10'h163, 4'b0001);
        check("R10 fall while disabled", {7'd0, irq3}, 8'd0);

        // R12 adapter write strobe
        bus_addr = 10'h151; iow_n = 1'b0; #1;
        check("R12 before edge", {7'd0, adp_wr}, 8'd0);
        @(negedge clk);
        check("R12 strobe", {7'd0, adp_wr}, 8'd1);
        iow_n = 1'b1;
        @(negedge clk);
        check("R12 released", {7'd0, adp_wr}, 8'd0);
        bus_addr = 10'h161; iow_n = 1'b0;
        @(negedge clk);
        check("R12 system write", {7'd0, adp_wr}, 8'd0);
        iow_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule